// File: doc/BRIEF.md
# Sample Register and Conversion-Trigger Front End

This block is the digital side of a single-channel 12-bit converter, reached through a 32-bit memory-mapped register port. Software loads a sample into a holding value through one of three write windows. One takes a right-justified 12-bit value, one a 12-bit value justified to bit 15, and one an 8-bit value that becomes the top of the 12-bit code. The holding value is copied into the output code register in one of two ways. With triggering off, the copy happens one clock after the data write. With triggering on, the copy happens on a rising edge of the selected trigger, and only while the channel is enabled.

Five hardware trigger lines and a self-clearing software trigger bit can start a copy. They are chosen by a 3-bit code that has two dead values. Each accepted copy can raise a DMA request that is held until it is acknowledged. A second accepted copy while a request is still pending is an underrun. It sets a sticky status flag, switches DMA off and, if enabled, drives the interrupt line. The buffer-off control bit is stored and brought out as a pin.

Register accesses use a valid/ready request channel and a valid/ready read-response channel. A request is taken on a clock where `bus_valid` and `bus_ready` are both high. Each accepted read produces one response beat. `rsp_valid` and `rsp_data` stay fixed until `rsp_ready` is seen high. While a beat is waiting, `bus_ready` is low and no new request is taken.

Top module: `dac_frontend`

## Requirements
- R1: After reset, every register reads zero, `dac_code`, `dma_req`, `irq`, `dac_enable` and `buf_off` are low, and `bus_ready` is high.
- R2: Control register (offset 0x00) fields: bit 0 enable, bit 1 buffer off, bit 2 trigger enable, bits 5:3 source code, bit 12 DMA enable, bit 13 underrun interrupt enable. Other bits read 0. Bit 0 drives `dac_enable` and bit 1 drives `buf_off`.
- R3: A write to offset 0x08 loads the holding value from bits 11:0. Reading 0x08 returns the holding value in bits 11:0.
- R4: A write to offset 0x0C loads the holding value from bits 15:4. Reading 0x0C returns it in bits 15:4 with bits 3:0 zero.
- R5: A write to offset 0x10 puts bits 7:0 into the top 8 bits of the holding value and zeroes its low 4 bits. Reading 0x10 returns the top 8 bits of the holding value.
- R6: With trigger enable clear, a data write accepted at clock edge k appears on `dac_code` and at offset 0x2C after edge k+1. Offset 0x2C is read-only, and writes to it are ignored.
- R7: With trigger enable set, the copy happens only at an edge where the selected hardware line is high having been low at the previous edge, and only while enable (bit 0) is set. A line held high, or a line that is not selected, causes no copy.
- R8: Source codes 2 and 5 never start a copy.
- R9: Source codes 0, 1, 3, 4 and 6 select `trig_in[0]` through `trig_in[4]` in that order. Code 7 selects the software trigger, which is bit 0 at offset 0x04. That bit is taken one edge after it is written, if enable and trigger enable are both set; it then reads 0. If it is not taken, it stays set.
- R10: With DMA enable set, each accepted copy raises `dma_req`. The request stays high until a clock where `dma_ack` is high.
- R11: An accepted copy while `dma_req` is high and `dma_ack` is low sets status bit 13 (offset 0x34) and clears control bit 12.
- R12: Writing 1 to status bit 13 clears it, and writing 0 leaves it set. `irq` is high exactly when the flag and control bit 13 are both set.
- R13: While `rsp_valid` is high and `rsp_ready` is low, `bus_ready` is low, no request is taken, and `rsp_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request can be taken |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_data | output | 32 | Read response data |
| trig_in | input | 5 | Hardware trigger lines |
| dma_ack | input | 1 | DMA request acknowledge |
| dma_req | output | 1 | DMA request |
| dac_code | output | 12 | Output code to the converter |
| dac_enable | output | 1 | Channel enable |
| buf_off | output | 1 | Output buffer off |
| irq | output | 1 | Underrun interrupt |

## Verification
Samples go in through each of the three write windows, using values whose upper bits would show through if the wrong field were taken. This separates the alignments from each other and from plain truncation. Trigger tests pulse the selected line, an unselected line and the dead codes, hold a line high across later data writes, and repeat with the enable bit clear. This distinguishes edge detection from level sensing and shows that the source decode and the enable gate are both in force. The DMA tests give one acknowledged request, then two copies with no acknowledge, with and without the interrupt enable. This separates request holding, underrun detection, the write-one-to-clear rule and the interrupt gate. A stalled read response is held against a competing write, which shows that back-pressure both freezes the response and blocks the request.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int NUM_HW  = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SWT   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_R12   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_L12   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_R8    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h34;

  localparam int CB_EN   = 0;
  localparam int CB_BOFF = 1;
  localparam int CB_TEN  = 2;
  localparam int CB_SRC  = 3;
  localparam int CB_DMA  = 12;
  localparam int CB_IE   = 13;
  localparam int SB_UDR  = 13;

  typedef enum logic [2:0] {
    SRC_LINE0 = 3'd0,
    SRC_LINE1 = 3'd1,
    SRC_DEAD2 = 3'd2,
    SRC_LINE2 = 3'd3,
    SRC_LINE3 = 3'd4,
    SRC_DEAD5 = 3'd5,
    SRC_LINE4 = 3'd6,
    SRC_SOFT  = 3'd7
  } trig_src_e;

  typedef struct packed {
    logic      irq_en;
    logic      dma_en;
    trig_src_e src;
    logic      trig_en;
    logic      buf_off;
    logic      en;
  } ctrl_t;

  function automatic logic [BUS_W-1:0] ctrl_word(ctrl_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CB_EN]          = c.en;
    w[CB_BOFF]        = c.buf_off;
    w[CB_TEN]         = c.trig_en;
    w[CB_SRC +: 3]    = c.src;
    w[CB_DMA]         = c.dma_en;
    w[CB_IE]          = c.irq_en;
    return w;
  endfunction
endpackage

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int DW = 12,
  parameter int NW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     out_code,
  input  logic              take_sw,
  input  logic              dma_stop,
  input  logic              underrun_set,
  output ctrl_t             ctrl,
  output logic [DW-1:0]     hold,
  output logic              swtr,
  output logic              flag,
  output logic              data_wr,
  output logic [BUS_W-1:0]  rd_word
);
  localparam int LEFT_LSB = 16 - DW;
  localparam int PAD      = DW - NW;

  logic wr_ctrl, wr_swt, wr_r12, wr_l12, wr_r8, wr_stat;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == OFS_CTRL);
    wr_swt  = wr_en && (wr_addr == OFS_SWT);
    wr_r12  = wr_en && (wr_addr == OFS_R12);
    wr_l12  = wr_en && (wr_addr == OFS_L12);
    wr_r8   = wr_en && (wr_addr == OFS_R8);
    wr_stat = wr_en && (wr_addr == OFS_STAT);
    data_wr = wr_r12 || wr_l12 || wr_r8;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.en      <= wr_data[CB_EN];
        ctrl.buf_off <= wr_data[CB_BOFF];
        ctrl.trig_en <= wr_data[CB_TEN];
        ctrl.src     <= trig_src_e'(wr_data[CB_SRC +: 3]);
        ctrl.dma_en  <= wr_data[CB_DMA];
        ctrl.irq_en  <= wr_data[CB_IE];
      end
      if (dma_stop) ctrl.dma_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hold <= '0;
    else if (wr_r12) hold <= wr_data[DW-1:0];
    else if (wr_l12) hold <= wr_data[15:LEFT_LSB];
    else if (wr_r8)  hold <= {wr_data[NW-1:0], {PAD{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       swtr <= 1'b0;
    else if (take_sw) swtr <= 1'b0;
    else if (wr_swt && wr_data[0]) swtr <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            flag <= 1'b0;
    else if (underrun_set) flag <= 1'b1;
    else if (wr_stat && wr_data[SB_UDR]) flag <= 1'b0;
  end

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      OFS_CTRL: rd_word = ctrl_word(ctrl);
      OFS_SWT:  rd_word[0] = swtr;
      OFS_R12:  rd_word[DW-1:0] = hold;
      OFS_L12:  rd_word[15:LEFT_LSB] = hold;
      OFS_R8:   rd_word[NW-1:0] = hold[DW-1 -: NW];
      OFS_OUT:  rd_word[DW-1:0] = out_code;
      OFS_STAT: rd_word[SB_UDR] = flag;
      default:  rd_word = '0;
    endcase
  end

  // R9
  sw_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swtr && take_sw) |=> !swtr);
  // R11
  dma_stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |=> !ctrl.dma_en);
  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_set |=> flag);
endmodule

// File: rtl/dacfe_trig.sv
module dacfe_trig
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] trig_in,
  input  trig_src_e         src,
  input  logic              en,
  input  logic              trig_en,
  input  logic              swtr,
  output logic              fire,
  output logic              take_sw
);
  logic [NUM_HW-1:0] prev;
  logic [NUM_HW-1:0] rise;
  logic              hw_hit;
  logic              armed;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= trig_in;
  end

  always_comb begin
    rise = trig_in & ~prev;
    case (src)
      SRC_LINE0: hw_hit = rise[0];
      SRC_LINE1: hw_hit = rise[1];
      SRC_LINE2: hw_hit = rise[2];
      SRC_LINE3: hw_hit = rise[3];
      SRC_LINE4: hw_hit = rise[4];
      default:   hw_hit = 1'b0;
    endcase
    armed   = en && trig_en;
    take_sw = armed && (src == SRC_SOFT) && swtr;
    fire    = armed && (hw_hit || take_sw);
  end

  // R8
  dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DEAD2 || src == SRC_DEAD5) |-> !fire);
  // R7
  fire_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (en && trig_en));
endmodule

// File: rtl/dacfe_dma.sv
module dacfe_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic dma_en,
  input  logic ack,
  output logic req,
  output logic underrun
);
  always_comb underrun = accept && dma_en && req && !ack;

  always_ff @(posedge clk) begin
    if (!rst_n)                            req <= 1'b0;
    else if (accept && dma_en && !underrun) req <= 1'b1;
    else if (ack)                           req <= 1'b0;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
endmodule

// File: rtl/dac_frontend.sv
module dac_frontend
  import dacfe_pkg::*;
#(
  parameter int DW = 12,
  parameter int NW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BUS_W-1:0]  rsp_data,
  input  logic [NUM_HW-1:0] trig_in,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic [DW-1:0]     dac_code,
  output logic              dac_enable,
  output logic              buf_off,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [DW-1:0]    hold;
  logic             swtr, flag, data_wr;
  logic [BUS_W-1:0] rd_word;
  logic             fire, take_sw, underrun;
  logic             wr_en, rd_en, load_pending;

  always_comb begin
    bus_ready = !rsp_valid || rsp_ready;
    wr_en     = bus_valid && bus_ready && bus_write;
    rd_en     = bus_valid && bus_ready && !bus_write;
  end

  dacfe_regs #(.DW(DW), .NW(NW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .rd_addr(bus_addr), .out_code(dac_code),
    .take_sw(take_sw), .dma_stop(underrun), .underrun_set(underrun),
    .ctrl(ctrl), .hold(hold), .swtr(swtr), .flag(flag),
    .data_wr(data_wr), .rd_word(rd_word)
  );

  dacfe_trig u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .src(ctrl.src),
    .en(ctrl.en), .trig_en(ctrl.trig_en), .swtr(swtr),
    .fire(fire), .take_sw(take_sw)
  );

  dacfe_dma u_dma (
    .clk(clk), .rst_n(rst_n), .accept(fire), .dma_en(ctrl.dma_en),
    .ack(dma_ack), .req(dma_req), .underrun(underrun)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) load_pending <= 1'b0;
    else        load_pending <= data_wr && !ctrl.trig_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    dac_code <= '0;
    else if (fire || load_pending) dac_code <= hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_en) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    dac_enable = ctrl.en;
    buf_off    = ctrl.buf_off;
    irq        = flag && ctrl.irq_en;
  end

  // R13
  rsp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R6
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !load_pending) |=> $stable(dac_code));
endmodule

// File: tb/tb_dac_frontend.sv
module tb_dac_frontend;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [4:0]  trig_in = '0;
  logic        dma_ack = 1'b0, dma_req;
  logic [11:0] dac_code;
  logic        dac_enable, buf_off, irq;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_frontend dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .trig_in(trig_in), .dma_ack(dma_ack), .dma_req(dma_req),
    .dac_code(dac_code), .dac_enable(dac_enable), .buf_off(buf_off), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic pulse(input int idx);
    @(posedge clk); #1;
    trig_in[idx] = 1'b1;
    @(posedge clk); #1;
    trig_in[idx] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 bus_ready", 32'(bus_ready), 1);
    check("R1 dac_code", 32'(dac_code), 0);
    check("R1 pins", {dma_req, irq, dac_enable, buf_off}, 0);
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h34, d); check("R1 status", d, 0);
    rd(8'h2C, d); check("R1 out", d, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 ctrl readback", d, 32'h0000_303F);
    check("R2 pins", {dac_enable, buf_off}, 2'b11);
    wr(8'h00, 32'h0);
    check("R2 pins cleared", {dac_enable, buf_off}, 0);
  endtask

  task automatic t_right();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_F5A5);
    check("R6 not yet", 32'(dac_code), 0);
    tick(1);
    check("R6 one clock later", 32'(dac_code), 32'h5A5);
    rd(8'h08, d); check("R3 right readback", d, 32'h5A5);
    wr(8'h2C, 32'h123);
    rd(8'h2C, d); check("R6 out read-only", d, 32'h5A5);
  endtask

  task automatic t_left();
    logic [31:0] d;
    wr(8'h0C, 32'hFFFF_7C3F);
    tick(1);
    check("R4 left to code", 32'(dac_code), 32'h7C3);
    rd(8'h0C, d); check("R4 left readback", d, 32'h7C30);
    rd(8'h08, d); check("R4 via right window", d, 32'h7C3);
  endtask

  task automatic t_narrow();
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FF9E);
    tick(1);
    check("R5 narrow to code", 32'(dac_code), 32'h9E0);
    rd(8'h10, d); check("R5 narrow readback", d, 32'h9E);
  endtask

  task automatic t_hw();
    wr(8'h00, 32'h1D);
    wr(8'h08, 32'h111);
    tick(2);
    check("R7 no copy without edge", 32'(dac_code), 32'h9E0);
    pulse(1);
    check("R7 unselected line", 32'(dac_code), 32'h9E0);
    @(posedge clk); #1; trig_in[2] = 1'b1;
    @(posedge clk); #1;
    check("R9 code 3 selects line 2", 32'(dac_code), 32'h111);
    wr(8'h08, 32'h222);
    tick(3);
    check("R7 level held", 32'(dac_code), 32'h111);
    trig_in[2] = 1'b0;
    pulse(2);
    check("R7 second edge", 32'(dac_code), 32'h222);
    wr(8'h00, 32'h1C);
    wr(8'h08, 32'h333);
    pulse(2);
    check("R7 enable clear blocks", 32'(dac_code), 32'h222);
    wr(8'h00, 32'h25);
    pulse(4);
    check("R9 code 4 selects line 3 only", 32'(dac_code), 32'h222);
    pulse(3);
    check("R9 code 4 selects line 3", 32'(dac_code), 32'h333);
  endtask

  task automatic t_gap();
    wr(8'h08, 32'h444);
    wr(8'h00, 32'h15);
    for (int i = 0; i < 5; i++) pulse(i);
    check("R8 code 2 dead", 32'(dac_code), 32'h333);
    wr(8'h00, 32'h2D);
    for (int i = 0; i < 5; i++) pulse(i);
    check("R8 code 5 dead", 32'(dac_code), 32'h333);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    wr(8'h00, 32'h3C);
    wr(8'h04, 32'h1);
    tick(2);
    rd(8'h04, d); check("R9 not taken stays set", d, 1);
    check("R9 no copy when off", 32'(dac_code), 32'h333);
    wr(8'h00, 32'h3D);
    tick(1);
    check("R9 soft copy", 32'(dac_code), 32'h444);
    rd(8'h04, d); check("R9 self clear", d, 0);
    wr(8'h08, 32'h555);
    wr(8'h04, 32'h1);
    check("R9 not before next edge", 32'(dac_code), 32'h444);
    tick(1);
    check("R9 soft copy timing", 32'(dac_code), 32'h555);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    wr(8'h00, 32'h1005);
    wr(8'h08, 32'h0AA);
    pulse(0);
    check("R10 copy", 32'(dac_code), 32'h0AA);
    check("R10 req raised", 32'(dma_req), 1);
    tick(3);
    check("R10 req held", 32'(dma_req), 1);
    dma_ack = 1'b1; tick(1); dma_ack = 1'b0;
    check("R10 req cleared", 32'(dma_req), 0);
    rd(8'h34, d); check("R11 no underrun", d, 0);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    wr(8'h00, 32'h3005);
    pulse(0);
    pulse(0);
    rd(8'h34, d); check("R11 flag set", d, 32'h2000);
    rd(8'h00, d); check("R11 dma enable cleared", d, 32'h2005);
    check("R12 irq high", 32'(irq), 1);
    dma_ack = 1'b1; tick(1); dma_ack = 1'b0;
    wr(8'h34, 32'h0);
    rd(8'h34, d); check("R12 write 0 keeps", d, 32'h2000);
    wr(8'h34, 32'h2000);
    rd(8'h34, d); check("R12 w1c", d, 0);
    check("R12 irq low", 32'(irq), 0);
    wr(8'h00, 32'h1005);
    pulse(0); pulse(0);
    rd(8'h34, d); check("R11 flag again", d, 32'h2000);
    check("R12 irq masked", 32'(irq), 0);
    dma_ack = 1'b1; tick(1); dma_ack = 1'b0;
    wr(8'h34, 32'h2000);
  endtask

  task automatic t_backpressure();
    logic [31:0] d;
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h321);
    rsp_ready = 1'b0;
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h08;
    @(posedge clk); #1;
    bus_write = 1'b1; bus_wdata = 32'h777;
    check("R13 rsp valid", 32'(rsp_valid), 1);
    check("R13 bus_ready low", 32'(bus_ready), 0);
    tick(2);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R13 rsp held", rsp_data, 32'h321);
    rsp_ready = 1'b1;
    tick(1);
    check("R13 rsp drained", 32'(rsp_valid), 0);
    rd(8'h08, d); check("R13 stalled write refused", d, 32'h321);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_ctrl();
    t_right();
    t_left();
    t_narrow();
    t_hw();
    t_gap();
    t_sw();
    t_dma();
    t_underrun();
    t_backpressure();
    tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule